// File: doc/BRIEF.md
# Atomic Swap Sequencer

This block carries out an indivisible exchange at one memory location. A single command brings a base address, a source value and a size select (word or byte). The sequencer reads the location, then writes the source value back to the same address. It returns the old contents, aligned for a destination register, with the number of memory cycles the exchange took. The memory side is a simple request/acknowledge bus that can answer a request with an abort.

Commands enter through a valid/ready pair. `cmd_ready` is high only while the sequencer is idle, so a command waits at the port until the previous result has been taken. Results leave through a second valid/ready pair. While `rsp_valid` is high and `rsp_ready` is low, every result field holds its value; the result drops one cycle after the handshake completes. Only one exchange is in flight at a time. Keeping other bus masters away from the location, register write-back and instruction decoding are handled elsewhere.

The cycle total is the sum of the two bus phases plus one internal cycle. A phase lasts from the first cycle its request is raised up to and including the cycle of its acknowledge.

Top module: `swap_seq`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high after reset and low from that edge until the result has been taken. `cmd_ready` and `rsp_valid` are never high together.
- R2: After a command is taken, the block first issues a read (`mem_req`=1, `mem_we`=0) and then, only after a read acknowledge without abort, a write (`mem_we`=1). Both go to the command address, and `mem_nonseq` is high in every request cycle.
- R3: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until the cycle in which `mem_ack` is seen.
- R4: For a word (`cmd_byte`=0), `rsp_data` is the read word rotated right by 8 times address bits [1:0]. The written word is `cmd_src` unchanged, with `mem_byte`=0.
- R5: For a byte (`cmd_byte`=1), `mem_byte`=1 and `mem_wdata` is bits [7:0] of the source with zeros above. `rsp_data` is `mem_rdata[7:0]` zero-extended, and the upper read bits are ignored.
- R6: If the read acknowledge comes with `mem_abort`, no write request is issued. The result has `rsp_abort`=1 and `rsp_data`=0.
- R7: If the write acknowledge comes with `mem_abort`, the result has `rsp_abort`=1 and `rsp_data`=0. The loaded value is presented only after a clean write.
- R8: `rsp_cycles` equals read-phase cycles plus write-phase cycles plus one. The write phase counts zero when the read aborts, and the total saturates at its maximum.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_abort` and `rsp_cycles` stay stable.
- R10: During and right after reset, `mem_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_addr | input | ADDR_W | Base address of the exchange |
| cmd_src | input | DATA_W | Value to store |
| cmd_byte | input | 1 | 1 = byte exchange, 0 = word exchange |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write data |
| mem_byte | output | 1 | Byte-size access |
| mem_nonseq | output | 1 | Access is non-sequential |
| mem_ack | input | 1 | Phase complete |
| mem_abort | input | 1 | Phase aborted (valid with mem_ack) |
| mem_rdata | input | DATA_W | Read data (valid with mem_ack) |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_data | output | DATA_W | Aligned loaded value, zero on abort |
| rsp_abort | output | 1 | Exchange aborted |
| rsp_cycles | output | CNT_W | Total memory cycles of the exchange |

## Verification
The assertions assume the bus answers only a live request, with `mem_ack` high for a single cycle and dropped in the cycle after it is seen, and that `mem_abort` is read only together with `mem_ack`. The bench's bus model drives its outputs half a cycle after each edge. It raises the acknowledge once per phase after a chosen wait of zero to three cycles and clears it on the next falling edge. It flags an abort only on the phase picked for that exchange. Commands are offered only when idle, and `rsp_ready` is held low for random stretches so that the result hold rule is exercised.

// File: rtl/swap_pkg.sv
package swap_pkg;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_LOAD = 2'd1,
    SW_STORE = 2'd2,
    SW_DONE = 2'd3
  } swap_state_e;

  // Adds three counts and clamps the result to the all-ones value of w bits.
  function automatic logic [31:0] sat_sum3(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] c,
                                            input int unsigned w);
    logic [33:0] s;
    logic [33:0] lim;
    s   = {2'b00, a} + {2'b00, b} + {2'b00, c};
    lim = (34'd1 << w) - 34'd1;
    return (s > lim) ? lim[31:0] : s[31:0];
  endfunction

endpackage

// File: rtl/swap_align.sv
module swap_align #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]                       rdata,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]        lane,
  input  logic                                    is_byte,
  output logic [DATA_W-1:0]                       aligned
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int SH_W  = $clog2(LANES);

  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   zext;

  assign doubled = {rdata, rdata};

  // One candidate per lane count; the lane index picks the rotation.
  logic [DATA_W-1:0] rot_opt [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_rot
    assign rot_opt[g] = doubled[g*LANE_W +: DATA_W];
  end

  assign rotated = rot_opt[lane];
  assign zext    = {{(DATA_W-LANE_W){1'b0}}, rdata[LANE_W-1:0]};
  assign aligned = is_byte ? zext : rotated;

  // r4_: zero rotation must return the word unchanged
  always_comb begin
    if (!is_byte && lane == SH_W'(0)) a_no_rot_r4: assert (aligned == rdata);
  end
endmodule

// File: rtl/swap_phase_cnt.sv
module swap_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (run && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  // Cycles so far including the current one.
  assign total = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;

  p_cnt_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_src,
  input  logic              cmd_byte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_byte,
  output logic              mem_nonseq,
  input  logic              mem_ack,
  input  logic              mem_abort,
  input  logic [DATA_W-1:0] loaded,
  input  logic [CNT_W-1:0]  phase_total,
  output logic              cnt_clr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_abort,
  output logic [CNT_W-1:0]  rsp_cycles
);
  swap_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q;
  logic              byte_q;
  logic [DATA_W-1:0] ld_q;
  logic              abort_q;
  logic [CNT_W-1:0]  rd_cyc_q;
  logic [CNT_W-1:0]  sum_q;

  assign cmd_ready  = (st_q == SW_IDLE);
  assign mem_req    = (st_q == SW_LOAD) || (st_q == SW_STORE);
  assign mem_we     = (st_q == SW_STORE);
  assign mem_addr   = addr_q;
  assign mem_byte   = byte_q;
  assign mem_nonseq = mem_req;
  assign mem_wdata  = byte_q ? {{(DATA_W-LANE_W){1'b0}}, src_q[LANE_W-1:0]} : src_q;
  assign cnt_clr    = (st_q == SW_IDLE) || (st_q == SW_LOAD && mem_ack);

  assign rsp_valid  = (st_q == SW_DONE);
  assign rsp_abort  = rsp_valid && abort_q;
  assign rsp_data   = (rsp_valid && !abort_q) ? ld_q : '0;
  assign rsp_cycles = rsp_valid ? sum_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SW_IDLE;
      addr_q   <= '0;
      src_q    <= '0;
      byte_q   <= 1'b0;
      ld_q     <= '0;
      abort_q  <= 1'b0;
      rd_cyc_q <= '0;
      sum_q    <= '0;
    end else begin
      unique case (st_q)
        SW_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          src_q   <= cmd_src;
          byte_q  <= cmd_byte;
          abort_q <= 1'b0;
          st_q    <= SW_LOAD;
        end
        SW_LOAD: if (mem_ack) begin
          if (mem_abort) begin
            abort_q <= 1'b1;
            ld_q    <= '0;
            sum_q   <= CNT_W'(sat_sum3(32'(phase_total), 32'd0, 32'd1, CNT_W));
            st_q    <= SW_DONE;
          end else begin
            ld_q     <= loaded;
            rd_cyc_q <= phase_total;
            st_q     <= SW_STORE;
          end
        end
        SW_STORE: if (mem_ack) begin
          abort_q <= mem_abort;
          sum_q   <= CNT_W'(sat_sum3(32'(rd_cyc_q), 32'(phase_total), 32'd1, CNT_W));
          st_q    <= SW_DONE;
        end
        SW_DONE: if (rsp_ready) st_q <= SW_IDLE;
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  p_excl_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  p_take_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (mem_req && !mem_we && !cmd_ready));

  p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack && !mem_abort));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_no_wr_on_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && mem_abort) |=> (!mem_req && rsp_valid && rsp_abort));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_abort) && $stable(rsp_cycles)));
endmodule

// File: rtl/swap_seq.sv
module swap_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_src,
  input  logic              cmd_byte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_byte,
  output logic              mem_nonseq,
  input  logic              mem_ack,
  input  logic              mem_abort,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_abort,
  output logic [CNT_W-1:0]  rsp_cycles
);
  localparam int SH_W = $clog2(DATA_W / LANE_W);

  logic [DATA_W-1:0] loaded;
  logic [CNT_W-1:0]  phase_total;
  logic              cnt_clr;

  swap_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_align (
    .rdata   (mem_rdata),
    .lane    (mem_addr[SH_W-1:0]),
    .is_byte (mem_byte),
    .aligned (loaded)
  );

  swap_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .run   (mem_req),
    .total (phase_total)
  );

  swap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_addr    (cmd_addr),
    .cmd_src     (cmd_src),
    .cmd_byte    (cmd_byte),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_byte    (mem_byte),
    .mem_nonseq  (mem_nonseq),
    .mem_ack     (mem_ack),
    .mem_abort   (mem_abort),
    .loaded      (loaded),
    .phase_total (phase_total),
    .cnt_clr     (cnt_clr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_abort   (rsp_abort),
    .rsp_cycles  (rsp_cycles)
  );

  p_min_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_abort) |-> (rsp_cycles >= CNT_W'(3)));

  p_quiet_reset_r10: assert property (@(posedge clk)
    $past(!rst_n) |-> (!mem_req && !rsp_valid));
endmodule

// File: tb/tb_swap_seq.sv
module tb_swap_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_src = '0;
  logic        cmd_byte = 1'b0;
  logic        mem_req, mem_we, mem_byte, mem_nonseq;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_abort = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_abort;
  logic [7:0]  rsp_cycles;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  swap_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_src(cmd_src), .cmd_byte(cmd_byte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_byte(mem_byte), .mem_nonseq(mem_nonseq), .mem_ack(mem_ack),
    .mem_abort(mem_abort), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_abort(rsp_abort),
    .rsp_cycles(rsp_cycles)
  );

  // Bus model state
  logic [31:0] mem [16];
  int lat_rd = 0, lat_wr = 0, abort_ph = 0, wcnt = 0;
  int rd_seen = 0, wr_seen = 0, bad_order = 0, bad_addr = 0, bad_ns = 0;
  logic [31:0] exp_addr = '0;

  function automatic logic [31:0] ror32(input logic [31:0] v, input int n);
    if (n == 0) return v;
    return (v >> (8*n)) | (v << (32 - 8*n));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_abort = 1'b0;
      wcnt = 0;
    end
    if (rst_n && mem_req) begin
      if (mem_addr != exp_addr) bad_addr++;
      if (!mem_nonseq) bad_ns++;
      if (mem_we) wr_seen++;
      else begin
        rd_seen++;
        if (wr_seen != 0) bad_order++;
      end
      if (wcnt == (mem_we ? lat_wr : lat_rd)) begin
        mem_ack = 1'b1;
        mem_abort = (abort_ph == (mem_we ? 2 : 1));
        if (!mem_we) begin
          if (mem_byte)
            mem_rdata = {$urandom() % 32'h0100_0000, 8'h00} |
                        32'((mem[mem_addr[5:2]] >> (8*mem_addr[1:0])) & 32'hFF);
          else
            mem_rdata = mem[mem_addr[5:2]];
        end else if (!mem_abort) begin
          if (mem_byte)
            mem[mem_addr[5:2]][8*mem_addr[1:0] +: 8] = mem_wdata[7:0];
          else
            mem[mem_addr[5:2]] = mem_wdata;
        end
      end else wcnt++;
    end
  end

  task automatic swap(input logic [31:0] a, input logic [31:0] src, input bit byt,
                      input int lr, input int lw, input int ab);
    logic [31:0] old, exp_data, exp_mem, wdat;
    int exp_cyc, exp_wr, n;
    old = mem[a[5:2]];
    exp_data = byt ? 32'((old >> (8*a[1:0])) & 32'hFF) : ror32(old, int'(a[1:0]));
    exp_mem = old;
    wdat = byt ? {24'h0, src[7:0]} : src;
    if (ab == 0) begin
      if (byt) exp_mem[8*a[1:0] +: 8] = src[7:0];
      else exp_mem = src;
    end
    if (ab != 0) exp_data = 32'h0;
    exp_wr = (ab == 1) ? 0 : lw + 1;
    exp_cyc = (lr + 1) + exp_wr + 1;
    lat_rd = lr; lat_wr = lw; abort_ph = ab; exp_addr = a;
    rd_seen = 0; wr_seen = 0; bad_order = 0; bad_addr = 0; bad_ns = 0;
    @(negedge clk);
    check(cmd_ready, "R1 idle ready", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_src = src; cmd_byte = byt;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!cmd_ready, "R1 busy after accept", 32'(cmd_ready), 32'd0);
    n = 0;
    while (!rsp_valid && n < 50) begin
      if (mem_req && mem_we) check(mem_wdata == wdat && mem_byte == byt,
                                    byt ? "R5 write data" : "R4 write data", mem_wdata, wdat);
      @(negedge clk); n++;
    end
    check(rsp_valid, "R1 response arrives", 32'(rsp_valid), 32'd1);
    check(rsp_data == exp_data, byt ? "R5 load value" : (ab != 0 ? "R7 data on abort" : "R4 load value"),
          rsp_data, exp_data);
    check(rsp_abort == (ab != 0), ab == 1 ? "R6 abort flag" : "R7 abort flag",
          32'(rsp_abort), 32'(ab != 0));
    check(rsp_cycles == 8'(exp_cyc), "R8 cycle total", 32'(rsp_cycles), 32'(exp_cyc));
    check(wr_seen == exp_wr, ab == 1 ? "R6 no write after read abort" : "R2 write issued",
          32'(wr_seen), 32'(exp_wr));
    check(bad_order == 0 && bad_addr == 0 && bad_ns == 0 && rd_seen == lr + 1,
          "R2 order address nonseq", 32'(bad_order + bad_addr + bad_ns), 32'd0);
    check(mem[a[5:2]] == exp_mem, "R2 memory after swap", mem[a[5:2]], exp_mem);
    repeat ($urandom() % 4) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == exp_data && rsp_cycles == 8'(exp_cyc),
            "R9 hold under back-pressure", rsp_data, exp_data);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && cmd_ready, "R1 release after take", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mem[i] = $urandom();
    repeat (3) @(negedge clk);
    check(!mem_req && !rsp_valid && cmd_ready, "R10 reset state", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !rsp_valid, "R10 after reset", 32'(rsp_valid), 32'd0);
    mem[1] = 32'hA1B2_C3D4;
    swap(32'h0000_0004, 32'h1111_2222, 1'b0, 0, 0, 0);
    mem[2] = 32'h8899_AABB;
    swap(32'h0000_0009, 32'h3333_4444, 1'b0, 1, 2, 0);
    mem[3] = 32'h0102_0304;
    swap(32'h0000_000E, 32'h5555_6666, 1'b0, 0, 3, 0);
    mem[4] = 32'hDEAD_BEEF;
    swap(32'h0000_0013, 32'h7777_8888, 1'b0, 2, 0, 0);
    mem[5] = 32'hF0E1_D2C3;
    swap(32'h0000_0016, 32'hFFFF_FF5A, 1'b1, 1, 1, 0);
    swap(32'h0000_0018, 32'hCAFE_F00D, 1'b0, 3, 1, 1);
    swap(32'h0000_001D, 32'h0000_00A5, 1'b1, 0, 2, 2);
    swap(32'h0000_0020, 32'h1234_5678, 1'b0, 0, 0, 2);
    for (int k = 0; k < 40; k++) begin
      swap({26'h0, 6'($urandom())}, $urandom(), 1'($urandom()),
           int'($urandom() % 4), int'($urandom() % 4),
           (($urandom() % 4) == 0) ? int'(1 + $urandom() % 2) : 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule